// File: doc/BRIEF.md
# Dual-Mode BCD Hour Counter

This block keeps the hour of a real-time clock as two BCD digits, tens and units, four bits each, ready for a seven-segment decoder. A mode input selects a 24-hour count (00 to 23) or a 12-hour count (12, 01 to 11) with a half-day flag that marks the afternoon. Every change happens on the rising clock edge. A count enable, normally the carry from the minute chain, gates each increment.

The datapath is two chained decimal digit stages. The units stage carries into the tens stage when it rolls over from 9. A small control block watches both digits and the mode. It reloads both digits together at the end of each mode's sequence, and it forces any value the current mode cannot show back to that mode's start value. A terminal-count output marks the enabled cycle whose edge ends the day, so a day counter can be cascaded.

The asynchronous active-low reset clears the digits to 00 and the flag to AM. A separate synchronous clear loads the start value of the selected mode.

Top module: `hour_bcd_counter`

## Requirements
- R1: While `rst_n` is low, `tens` and `units` are 0, `pm` is 0 and `day_tc` is 0.
- R2: With `mode_12h` = 0, each enabled edge advances the hour 00, 01, … 23, and from 23 it goes to 00.
- R3: `units` never exceeds 9. After an enabled edge in 24-hour mode `tens` is at most 2, and after an enabled edge in 12-hour mode it is at most 1.
- R4: With `mode_12h` = 1, each enabled edge advances the hour 12, 01, 02, … 11, and from 11 it goes back to 12.
- R5: In 12-hour mode `pm` inverts on the enabled edge from 11 to 12 and keeps its value on every other enabled edge. An enabled edge in 24-hour mode leaves `pm` at 0.
- R6: When `clr` = 1, the next edge loads 00 in 24-hour mode or 12 in 12-hour mode, with `pm` = 0, whatever `en` is.
- R7: With `en` = 0 and `clr` = 0, the edge leaves `tens`, `units` and `pm` unchanged.
- R8: `day_tc` is 1 exactly while `en` = 1, `clr` = 0, and the state is 23 in 24-hour mode or 11 with `pm` = 1 in 12-hour mode. In every other case it is 0.
- R9: If the held value is not legal in the selected mode, the next enabled edge loads that mode's start value instead of counting: 12 with `pm` = 0 in 12-hour mode, and 00 in 24-hour mode. In 12-hour mode 00 and 13–23 are not legal.
- R10: When `units` is 9 and the hour is not at a reload point, an enabled edge sets `units` to 0 and adds one to `tens`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear to the start value of the selected mode |
| en | input | 1 | Count enable |
| mode_12h | input | 1 | 1 selects 12-hour AM/PM, 0 selects 24-hour |
| tens | output | 4 | Tens digit, BCD |
| units | output | 4 | Units digit, BCD |
| pm | output | 1 | Half-day flag, 1 means PM |
| day_tc | output | 1 | Day rollover marker for cascading |

## Verification
A wrong digit state shows on `tens` and `units` on the very edge that produces it. A wrong reload decision, such as a missed 23 or 12 wrap or a skipped carry, shows one edge after the boundary hour. A wrong half-day flag may stay hidden on the digits, but it shows on `pm` at the 11-to-12 edge and on `day_tc` twelve hours later, so the bench runs full 12-hour cycles and checks `day_tc` before every edge. Mode switches from illegal hours and clears with the enable both high and low exercise the reload priority.

// File: rtl/hour_pkg.sv
package hour_pkg;
  localparam int DIGIT_W   = 4;
  localparam int DIGIT_MAX = 9;
  typedef logic [DIGIT_W-1:0] bcd_t;

  localparam bcd_t START12_TENS  = bcd_t'(1);
  localparam bcd_t START12_UNITS = bcd_t'(2);
  localparam bcd_t LAST24_TENS   = bcd_t'(2);
  localparam bcd_t LAST24_UNITS  = bcd_t'(3);
  localparam bcd_t LAST12_UNITS  = bcd_t'(1);
endpackage

// File: rtl/bcd_digit.sv
module bcd_digit #(
  parameter int W    = hour_pkg::DIGIT_W,
  parameter int MAXV = hour_pkg::DIGIT_MAX
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = W'(MAXV);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load)          q_nxt = load_val;
    else if (inc)      q_nxt = (q == TOP) ? '0 : q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/hour_seq_ctrl.sv
module hour_seq_ctrl
  import hour_pkg::*;
(
  input  bcd_t tens,
  input  bcd_t units,
  input  logic pm,
  input  logic en,
  input  logic clr,
  input  logic mode_12h,
  output logic load,
  output bcd_t ld_tens,
  output bcd_t ld_units,
  output logic units_inc,
  output logic tens_inc,
  output logic pm_nxt,
  output logic day_tc
);
  localparam bcd_t DMAX = bcd_t'(DIGIT_MAX);

  logic at_last24, at_noon12, at_eleven, bad24, bad12;

  always_comb begin
    at_last24 = (tens == LAST24_TENS) && (units == LAST24_UNITS);
    at_noon12 = (tens == START12_TENS) && (units == START12_UNITS);
    at_eleven = (tens == START12_TENS) && (units == LAST12_UNITS);
    bad24 = (units > DMAX) || (tens > LAST24_TENS) ||
            ((tens == LAST24_TENS) && (units > LAST24_UNITS));
    bad12 = (units > DMAX) || (tens > START12_TENS) ||
            ((tens == START12_TENS) && (units > START12_UNITS)) ||
            ((tens == '0) && (units == '0));
  end

  always_comb begin
    load      = 1'b0;
    ld_tens   = '0;
    ld_units  = '0;
    units_inc = 1'b0;
    pm_nxt    = pm;
    if (clr) begin
      load   = 1'b1;
      pm_nxt = 1'b0;
      if (mode_12h) begin
        ld_tens  = START12_TENS;
        ld_units = START12_UNITS;
      end
    end else if (en) begin
      if (!mode_12h) begin
        pm_nxt = 1'b0;
        if (bad24 || at_last24) load = 1'b1;
        else                    units_inc = 1'b1;
      end else if (bad12) begin
        load     = 1'b1;
        ld_tens  = START12_TENS;
        ld_units = START12_UNITS;
        pm_nxt   = 1'b0;
      end else if (at_noon12) begin
        load     = 1'b1;
        ld_units = bcd_t'(1);
      end else begin
        units_inc = 1'b1;
        if (at_eleven) pm_nxt = ~pm;
      end
    end
  end

  assign tens_inc = units_inc && (units == DMAX);
  assign day_tc   = en && !clr &&
                    ((!mode_12h && at_last24) || (mode_12h && at_eleven && pm));
endmodule

// File: rtl/hour_bcd_counter.sv
module hour_bcd_counter
  import hour_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic       mode_12h,
  output logic [3:0] tens,
  output logic [3:0] units,
  output logic       pm,
  output logic       day_tc
);
  logic load, units_inc, tens_inc, pm_nxt;
  bcd_t ld_tens, ld_units;

  hour_seq_ctrl u_ctrl (
    .tens(tens), .units(units), .pm(pm), .en(en), .clr(clr),
    .mode_12h(mode_12h), .load(load), .ld_tens(ld_tens), .ld_units(ld_units),
    .units_inc(units_inc), .tens_inc(tens_inc), .pm_nxt(pm_nxt), .day_tc(day_tc)
  );

  bcd_digit u_units (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(ld_units),
    .inc(units_inc), .q(units)
  );

  bcd_digit u_tens (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(ld_tens),
    .inc(tens_inc), .q(tens)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pm <= 1'b0;
    else        pm <= pm_nxt;
  end
endmodule

// File: rtl/hour_bcd_counter_chk.sv
module hour_bcd_counter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic       en,
  input logic       mode_12h,
  input logic [3:0] tens,
  input logic [3:0] units,
  input logic       pm,
  input logic       day_tc
);
  p_units_bcd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    units <= 4'd9);

  p_tens24_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mode_12h) |=> tens <= 4'd2);

  p_tens12_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && mode_12h) |=> tens <= 4'd1);

  p_wrap24_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !mode_12h && tens == 4'd2 && units == 4'd3) |=>
      (tens == 4'd0 && units == 4'd0));

  p_pm_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && mode_12h && tens == 4'd1 && units == 4'd1) |=>
      (pm != $past(pm) && tens == 4'd1 && units == 4'd2));

  p_clear12_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && mode_12h) |=> (tens == 4'd1 && units == 4'd2 && !pm));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> ($stable(tens) && $stable(units) && $stable(pm)));

  p_tc_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    day_tc |-> (en && !clr));
endmodule

bind hour_bcd_counter hour_bcd_counter_chk u_chk (.*);

// File: tb/hour_bcd_counter_bench.sv
`timescale 1ns/1ps
module hour_bcd_counter_bench;
  localparam real CLK_PERIOD = 5.0;

  logic clk = 1'b0;
  logic rst_n, clr, en, mode_12h;
  logic [3:0] tens, units;
  logic pm, day_tc;

  typedef struct {
    logic       tc;
    int         hour;
    logic       pm;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  int checks = 0;
  int errors = 0;
  int m_hour = 0;
  logic m_pm = 1'b0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hour_bcd_counter u_hour_bcd_counter (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .mode_12h(mode_12h),
    .tens(tens), .units(units), .pm(pm), .day_tc(day_tc)
  );

  task automatic check_state(input int hour, input logic p, input string tag);
    checks++;
    if (tens != 4'(hour / 10) || units != 4'(hour % 10) || pm != p) begin
      errors++;
      $display("FAIL %s: got %0d%0d pm=%0b, expected %0d%0d pm=%0b",
               tag, tens, units, pm, hour / 10, hour % 10, p);
    end
  endtask

  // driver: apply one cycle of inputs, model it, push expectation
  task automatic step(input logic e, input logic c, input logic m, input string tag);
    exp_t it;
    @(negedge clk);
    en = e; clr = c; mode_12h = m;
    #1;
    it.tc = 1'b0;
    if (c) begin
      m_hour = m ? 12 : 0;
      m_pm = 1'b0;
    end else if (e) begin
      if (!m) begin
        it.tc = (m_hour == 23);
        m_hour = (m_hour >= 23) ? 0 : m_hour + 1;
        m_pm = 1'b0;
      end else if (m_hour < 1 || m_hour > 12) begin
        m_hour = 12;
        m_pm = 1'b0;
      end else begin
        it.tc = (m_hour == 11) && m_pm;
        if (m_hour == 12)      m_hour = 1;
        else if (m_hour == 11) begin m_hour = 12; m_pm = ~m_pm; end
        else                   m_hour = m_hour + 1;
      end
    end
    it.hour = m_hour;
    it.pm = m_pm;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: day_tc before the edge (R8), digits and flag after it
  initial begin
    forever begin
      exp_t it;
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      checks++;
      if (day_tc != it.tc) begin
        errors++;
        $display("FAIL R8 (%s): day_tc=%0b expected %0b", it.tag, day_tc, it.tc);
      end
      @(posedge clk);
      #1;
      check_state(it.hour, it.pm, it.tag);
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; en = 1'b0; mode_12h = 1'b0;
    #(CLK_PERIOD * 2 + 1);
    check_state(0, 1'b0, "R1 reset");
    checks++;
    if (day_tc !== 1'b0) begin
      errors++;
      $display("FAIL R1: day_tc=%0b expected 0", day_tc);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R10: full 24-hour sweep with wrap
    for (int i = 0; i < 27; i++) step(1, 0, 0, "R2/R10 24h count");
    // R7: enable low holds
    for (int i = 0; i < 3; i++) step(0, 0, 0, "R7 hold");
    for (int i = 0; i < 12; i++) step(1, 0, 0, "R2 24h count");
    // R9: hour 15 is illegal in 12-hour mode
    step(1, 0, 1, "R9 illegal to 12h");
    // R4 R5: two full 12-hour cycles, crossing AM->PM->AM
    for (int i = 0; i < 26; i++) step(1, 0, 1, "R4/R5 12h count");
    step(0, 0, 1, "R7 hold 12h");
    // R6: clear with enable high and with enable low
    step(1, 1, 1, "R6 clear 12h");
    for (int i = 0; i < 11; i++) step(1, 0, 1, "R4 12h count");
    step(1, 0, 1, "R5 11 to 12");
    // back to 24-hour: 12 is legal, pm clears
    for (int i = 0; i < 4; i++) step(1, 0, 0, "R5 24h after PM");
    step(0, 1, 0, "R6 clear 24h en low");
    step(1, 0, 1, "R9 00 illegal in 12h");
    step(1, 1, 0, "R6 clear 24h");
    for (int i = 0; i < 24; i++) step(1, 0, 0, "R2 24h second day");
    step(0, 0, 0, "R7 final hold");
    wait (sb_q.size() == 0);
    @(posedge clk);
    #2;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule